// File: doc/BRIEF.md
# Write-Once Supply Mode Register

This block holds the supply configuration of a chip in one 32-bit memory-mapped word. The low byte chooses how the core supply is produced: a bypass path, a linear regulator, a step-down converter with a two-bit output level, or the converter and regulator together with the converter forced into high-power mode. Software may write that byte only once after a power-on reset. The first write is checked against the set of legal mode combinations. A legal value is stored. An illegal value is thrown away, but the byte still locks, the power-on default stays in force, and the supply-ready status reads 0 until the next power-on reset.

The upper bytes carry battery-charge and USB-supply controls. They have no write-once limit. A settle counter stands in for the analog regulators. After a legal non-bypass mode is accepted, the ready flag rises a fixed number of cycles later. Bypass mode is ready on the next cycle.

Only the power-on reset clears the stored word, the lock and the ready state. A system reset clears only the read-data output register.

Top module: `supply_cfg_reg`

## Requirements
- R1: Low-byte fields are: bit 0 bypass, bit 1 regulator enable, bit 2 step-down converter enable, bit 3 converter forced-high-power, bits 5:4 converter level. Bits 7:6 are not stored and read 0.
- R2: After power-on reset, the low byte accepts exactly one write (a write with `wr_be[0]`=1). Every later low-byte write leaves the stored byte and the ready flag unchanged.
- R3: A low-byte value is legal only when bits 3:0 equal one of: 0001 with level 00; 0010 with level 00; 0100 with any level; 1110 with any level. Every other value, all-zero included, is illegal.
- R4: An illegal first write is not stored and still sets the lock. From the cycle after that write, the ready flag stays 0 until a power-on reset.
- R5: At power-on reset the low byte is 0x02 (regulator only) and is treated as legal. `supply_ready` is 0 during reset and rises SETTLE_CYC clock edges after reset is released.
- R6: Bits 8 (charge enable) and 9 (charge resistor select) are written through `wr_be[1]`. Bits 24 (USB level detector enable) and 25 (USB regulator enable) are written through `wr_be[3]`. These bits may be rewritten any number of times. All other bits from 8 to 30 read 0.
- R7: A read strobe returns, one cycle later on `rd_data`, the stored word with the lock status in bit 31. `rd_data` holds its value between reads and is 0 after power-on reset.
- R8: While system reset is asserted, `rd_data` is cleared. The stored word, the lock and `supply_ready` are left unchanged.
- R9: When a legal non-bypass value is accepted, `supply_ready` is 0 from the next cycle on and rises exactly SETTLE_CYC clock edges after the accepting edge.
- R10: When the legal bypass value is accepted, `supply_ready` is 1 from the next cycle on.
- R11: A write with `wr_be[0]`=0 does not set the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low; clears read data only |
| wr_valid | input | 1 | Write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data; bit 31 is the lock status |
| supply_ready | output | 1 | Active supply configuration is settled and valid |

## Verification
The embedded properties check several invariants on every cycle: the stored low byte is always a legal combination; once the lock is set, it and the stored byte never change; an illegal attempt leaves the byte unchanged and keeps the ready flag low; the ready flag rises only when the settle count runs out or a bypass value is accepted; and untouched upper bytes hold their value.

Some behaviour can only be shown by the bench's scenarios. These are the full legality table, each case started from a fresh power-on reset, and the exact rise cycle of the ready flag. They also include recovery from an illegal write through power-on reset, and the fact that a system reset leaves the configuration intact while clearing only the read output.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    typedef struct packed {
        logic [1:0] rsvd;
        logic [1:0] level;
        logic       hp;
        logic       sd;
        logic       ldo;
        logic       byp;
    } low_cfg_t;

    localparam logic [7:0]  LOW_MASK    = 8'h3F;
    localparam logic [7:0]  LOW_DEFAULT = 8'h02;
    localparam logic [31:0] UPPER_MASK  = 32'h0300_0300;

    typedef struct packed {
        logic     locked;
        low_cfg_t low;
    } lock_st_t;

    function automatic logic cfg_is_valid(input low_cfg_t c);
        logic ok;
        case ({c.hp, c.sd, c.ldo, c.byp})
            4'b0001, 4'b0010: ok = (c.level == 2'b00) && (c.rsvd == 2'b00);
            4'b0100, 4'b1110: ok = (c.rsvd == 2'b00);
            default:          ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/scfg_lock_ctrl.sv
module scfg_lock_ctrl
    import scfg_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_low_en,
    input  logic [7:0] wr_low_data,
    output logic [7:0] low_q,
    output logic       locked,
    output logic       take_slow,
    output logic       take_byp,
    output logic       take_bad
);
    lock_st_t st_d, st_q;
    low_cfg_t wr_cfg;
    logic     attempt, legal;

    always_comb begin
        wr_cfg    = low_cfg_t'(wr_low_data & LOW_MASK);
        attempt   = wr_low_en && !st_q.locked;
        legal     = cfg_is_valid(wr_cfg);
        take_bad  = attempt && !legal;
        take_byp  = attempt && legal && wr_cfg.byp;
        take_slow = attempt && legal && !wr_cfg.byp;
        st_d      = st_q;
        if (attempt) begin
            st_d.locked = 1'b1;
            if (legal) st_d.low = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.locked <= 1'b0;
            st_q.low    <= low_cfg_t'(LOW_DEFAULT);
        end else begin
            st_q <= st_d;
        end
    end

    assign low_q  = st_q.low;
    assign locked = st_q.locked;

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.locked |=> (st_q.locked && $stable(st_q.low)));

    // R4
    bad_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        take_bad |=> (st_q.locked && (st_q.low == $past(st_q.low))));

    // R3
    stored_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_is_valid(st_q.low));

endmodule

// File: rtl/scfg_settle.sv
module scfg_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic take_slow,
    input  logic take_byp,
    input  logic take_bad,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
        logic          dead;
    } settle_st_t;

    settle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_bad) begin
            st_d.dead  = 1'b1;
            st_d.ready = 1'b0;
            st_d.cnt   = '0;
        end else if (take_byp) begin
            st_d.ready = 1'b1;
            st_d.cnt   = '0;
        end else if (take_slow) begin
            st_d.ready = 1'b0;
            st_d.cnt   = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE && !st_q.dead) st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt   <= LOAD;
            st_q.ready <= 1'b0;
            st_q.dead  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;

    // R4
    dead_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.dead |-> !st_q.ready);

    // R9
    settle_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.ready) |-> (($past(st_q.cnt) == ONE) || $past(take_byp)));

    // R9
    settle_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        take_slow |=> !st_q.ready);

    // R10
    bypass_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
        take_byp |=> st_q.ready);

endmodule

// File: rtl/scfg_upper.sv
module scfg_upper
    import scfg_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            wr_en,
    input  logic [NB-1:0]   be,
    input  logic [8*NB-1:0] data,
    output logic [8*NB-1:0] q
);
    typedef struct packed {
        logic [NB-1:0][7:0] lanes;
    } up_st_t;

    up_st_t             st_d, st_q;
    logic [NB-1:0][7:0] lane_nx;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam logic [7:0] LMASK = UPPER_MASK[8*g +: 8];
        if (g == 0) begin : g_low
            assign lane_nx[g] = 8'h00;
        end else begin : g_up
            assign lane_nx[g] = (wr_en && be[g]) ? (data[8*g +: 8] & LMASK)
                                                 : st_q.lanes[g];
        end
    end

    always_comb begin
        st_d.lanes = lane_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.lanes;

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/scfg_read_port.sv
module scfg_read_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          rd_valid,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DW-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sys_rst_n)    st_d.data = '0;
        else if (rd_valid) st_d.data = word_in;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

    // R8
    sys_rst_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> (st_q.data == '0));

    // R7
    rd_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_valid && sys_rst_n) |=> (st_q.data == $past(word_in)));

endmodule

// File: rtl/supply_cfg_reg.sv
module supply_cfg_reg
    import scfg_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        wr_valid,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    input  logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        supply_ready
);
    localparam int NB = 4;
    localparam int DW = 8 * NB;
    localparam logic [DW-1:0] READ_MASK =
        UPPER_MASK | {{(DW-8){1'b0}}, LOW_MASK} | {1'b1, {(DW-1){1'b0}}};

    logic [7:0]    low_q;
    logic          locked;
    logic          take_slow, take_byp, take_bad;
    logic [DW-1:0] upper_q;
    logic [DW-1:0] word;

    scfg_lock_ctrl u_lock (
        .clk         (clk),
        .por_n       (por_n),
        .wr_low_en   (wr_valid && wr_be[0]),
        .wr_low_data (wr_data[7:0]),
        .low_q       (low_q),
        .locked      (locked),
        .take_slow   (take_slow),
        .take_byp    (take_byp),
        .take_bad    (take_bad)
    );

    scfg_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk       (clk),
        .por_n     (por_n),
        .take_slow (take_slow),
        .take_byp  (take_byp),
        .take_bad  (take_bad),
        .ready     (supply_ready)
    );

    scfg_upper #(.NB(NB)) u_upper (
        .clk   (clk),
        .por_n (por_n),
        .wr_en (wr_valid),
        .be    (wr_be),
        .data  (wr_data),
        .q     (upper_q)
    );

    always_comb begin
        word = upper_q | {{(DW-8){1'b0}}, low_q};
        word[DW-1] = locked;
    end

    scfg_read_port #(.DW(DW)) u_rd (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .rd_valid  (rd_valid),
        .word_in   (word),
        .rd_data   (rd_data)
    );

    // R6
    rd_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((rd_data & ~READ_MASK) == '0));

    // R11
    no_lock_without_be0_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!locked && !(wr_valid && wr_be[0])) |=> !locked);

endmodule

// File: tb/sim_supply_cfg_reg.sv
module sim_supply_cfg_reg;
    localparam int S = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data;
    logic        supply_ready;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    supply_cfg_reg #(.SETTLE_CYC(S)) u0 (
        .clk, .por_n, .sys_rst_n, .wr_valid, .wr_be, .wr_data,
        .rd_valid, .rd_data, .supply_ready
    );

    // {written low byte, expected stored low byte, kind: 0 illegal, 1 settle, 2 bypass}
    localparam logic [23:0] VEC [12] = '{
        {8'h01, 8'h01, 8'd2},
        {8'h02, 8'h02, 8'd1},
        {8'h04, 8'h04, 8'd1},
        {8'h34, 8'h34, 8'd1},
        {8'h1E, 8'h1E, 8'd1},
        {8'hC4, 8'h04, 8'd1},
        {8'h00, 8'h02, 8'd0},
        {8'h03, 8'h02, 8'd0},
        {8'h06, 8'h02, 8'd0},
        {8'h08, 8'h02, 8'd0},
        {8'h11, 8'h02, 8'd0},
        {8'h05, 8'h02, 8'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_por();
        @(negedge clk) por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic do_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic do_read(output logic [31:0] v);
        @(negedge clk) rd_valid = 1'b1;
        @(negedge clk) rd_valid = 1'b0;
        v = rd_data;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        check("R7 rd_data at reset", rd_data, 32'h0);
        check("R5 ready low in reset", {31'b0, supply_ready}, 32'h0);
        por_n = 1'b1; sys_rst_n = 1'b1;
        repeat (S - 1) @(negedge clk);
        check("R5 ready before settle", {31'b0, supply_ready}, 32'h0);
        @(negedge clk);
        check("R5 ready after settle", {31'b0, supply_ready}, 32'h1);
        do_read(rv);
        check("R5 R7 default word", rv, 32'h0000_0002);

        // upper bytes, no low-byte enable
        do_write(4'b1010, 32'hFFFF_FFFF);
        do_read(rv);
        check("R6 R11 upper set", rv, 32'h0300_0302);
        do_write(4'b1000, 32'h0000_0000);
        do_read(rv);
        check("R6 clear bits 24/25", rv, 32'h0000_0302);
        do_write(4'b0100, 32'hFFFF_FFFF);
        do_read(rv);
        check("R6 byte 2 no bits", rv, 32'h0000_0302);
        do_write(4'b0010, 32'h0000_0100);
        do_read(rv);
        check("R6 rewrite bits 8/9", rv, 32'h0000_0102);

        // legality table, each from power-on reset
        for (int i = 0; i < 12; i++) begin
            logic [7:0] wl, el, kind;
            {wl, el, kind} = VEC[i];
            do_por();
            repeat (S + 2) @(negedge clk);
            check("R5 ready before write", {31'b0, supply_ready}, 32'h1);
            do_write(4'b0001, {24'hFFFFFF, wl});
            if (kind == 8'd2) begin
                check("R10 bypass ready next cycle", {31'b0, supply_ready}, 32'h1);
            end else if (kind == 8'd1) begin
                check("R9 ready drops", {31'b0, supply_ready}, 32'h0);
                repeat (S - 1) @(negedge clk);
                check("R9 ready still low", {31'b0, supply_ready}, 32'h0);
                @(negedge clk);
                check("R9 ready rises", {31'b0, supply_ready}, 32'h1);
            end else begin
                check("R4 ready low after bad", {31'b0, supply_ready}, 32'h0);
                repeat (S + 2) @(negedge clk);
                check("R4 ready stays low", {31'b0, supply_ready}, 32'h0);
            end
            do_read(rv);
            check("R1 R3 R4 stored low", rv, {1'b1, 23'b0, el});
            do_write(4'b0001, 32'h0000_0004);
            repeat (S + 2) @(negedge clk);
            do_read(rv);
            check("R2 second write ignored", rv, {1'b1, 23'b0, el});
            check("R2 ready unchanged", {31'b0, supply_ready}, {31'b0, kind != 8'd0});
        end

        // system reset keeps configuration
        do_por();
        repeat (S + 2) @(negedge clk);
        do_write(4'b0011, 32'h0000_0334);
        repeat (S + 2) @(negedge clk);
        do_read(rv);
        check("R6 R9 combined word", rv, 32'h8000_0334);
        @(negedge clk) sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 rd_data cleared", rd_data, 32'h0);
        check("R8 ready kept", {31'b0, supply_ready}, 32'h1);
        sys_rst_n = 1'b1;
        do_read(rv);
        check("R8 word kept", rv, 32'h8000_0334);
        do_write(4'b0001, 32'h0000_0001);
        do_read(rv);
        check("R8 R2 lock kept", rv, 32'h8000_0334);

        // illegal write recovered only by power-on reset
        do_por();
        repeat (S + 2) @(negedge clk);
        do_write(4'b0001, 32'h0000_0000);
        @(negedge clk) sys_rst_n = 1'b0;
        @(negedge clk) sys_rst_n = 1'b1;
        repeat (S) @(negedge clk);
        check("R4 R8 still not ready", {31'b0, supply_ready}, 32'h0);
        do_por();
        repeat (S + 1) @(negedge clk);
        check("R4 ready after por", {31'b0, supply_ready}, 32'h1);
        do_write(4'b0001, 32'h0000_0002);
        do_read(rv);
        check("R4 write accepted after por", rv, 32'h8000_0002);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule